// File: doc/BRIEF.md
# Segment Lookaside Buffer Array

This block is a small, fully associative table of segment descriptors used in front of a hashed page-table walker. Each slot holds two 64-bit words: an effective-segment word (segment tag plus a valid flag) and a virtual-segment word (segment-size field, page-size code and the rest of the descriptor). A dedicated lookup port compares an effective address against every slot in parallel. Each slot matches either as a 256 MB segment or as a 1 TB segment, depending on its own size field. The port returns a combinational one-hot hit vector and, one cycle later, a registered hit flag, slot index and descriptor word.

A maintenance port carries one operation per cycle. It can write a slot, read either word of a slot, search for the descriptor of an address, invalidate the entry that matches an address (local or global flavour), or invalidate all entries except slot 0. Illegal writes and reads are refused with an error flag. Invalidations raise a one-cycle local or global translation-flush request.

Top module: `slb_array`

## Requirements
- R1: After reset every slot is zero: no lookup hits, and both words of every slot read back as zero.
- R2: A slot whose size field (bits 63:62 of the descriptor word) is 00 hits when its stored tag word equals the address with bits 27:0 cleared and bit 27 (valid) set.
- R3: A slot whose size field is 01 hits when its stored tag word equals the address with bits 39:0 cleared and bit 27 (valid) set.
- R4: `lk_hit_vec` is one-hot or zero. When several slots would hit, only the lowest-numbered one is reported, both on the lookup port and for search and invalidate-by-address.
- R5: A write (op code 0) stores `op_addr` with bits 11:0 cleared as the tag word and `op_data` as the descriptor word, in the slot given by `op_addr[11:0]`. Read-tag (code 1) and read-descriptor (code 2) return the stored word one cycle after the operation. Write responses carry data 0.
- R6: A write is refused with `rsp_err` and leaves the table unchanged when any of these holds: the slot is at or above `NUM_ENTRIES`; any of `op_addr[26:12]` is set; the size field is 1x; or the size field is 01 with `ONE_TB_EN` = 0.
- R7: A write is also refused when the page-size code {`op_data[8]`, `op_data[5:4]`} matches none of the entries in `PAGE_ENCS` (default 000, 101, 100).
- R8: A read of either word with a slot at or above `NUM_ENTRIES` returns `rsp_err` with data 0.
- R9: Search (code 3) returns the descriptor of the winning slot for `op_addr`, or all ones on a miss. With `mode64` low it returns `rsp_err` and data 0.
- R10: Invalidate-by-address (code 4 local, code 5 global) clears the valid bit of the winning slot and pulses `flush_local` or `flush_global` respectively. On a miss nothing changes and no flush is raised.
- R11: Invalidate-all (code 6) clears the valid bit of slots 1 and up and never touches slot 0. It pulses `flush_local` only when at least one of those slots was valid.
- R12: When `lk_valid` is high, the next cycle shows `lk_rsp_valid`, the hit flag, the winning index and that slot's descriptor word (zero on a miss).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode64 | input | 1 | Processor is in 64-bit mode (enables search) |
| op_valid | input | 1 | Maintenance operation present |
| op_code | input | 3 | 0 write, 1 read tag, 2 read descriptor, 3 search, 4 inval local, 5 inval global, 6 inval all |
| op_addr | input | 64 | Address operand (slot in bits 11:0 for indexed ops) |
| op_data | input | 64 | Descriptor word for writes |
| rsp_valid | output | 1 | Response for the previous cycle's operation |
| rsp_err | output | 1 | Operation refused |
| rsp_data | output | 64 | Read or search result |
| flush_local | output | 1 | Local translation-flush request pulse |
| flush_global | output | 1 | Global translation-flush request pulse |
| lk_valid | input | 1 | Lookup request |
| lk_ea | input | 64 | Lookup effective address |
| lk_hit_vec | output | NUM_ENTRIES | Combinational one-hot hit vector |
| lk_rsp_valid | output | 1 | Registered lookup result present |
| lk_rsp_hit | output | 1 | Registered lookup hit |
| lk_rsp_idx | output | IDX_W | Registered winning slot |
| lk_rsp_vsid | output | 64 | Registered descriptor word of the winning slot |

## Verification
The hit vector is combinational, so the bench reads it 1 ns after driving `lk_ea` in the same cycle. Every other result comes from one register stage: responses, flush pulses and registered lookup results. The bench samples these 1 ns after the first rising edge that follows the stimulus. A write is visible to a lookup or read issued on the next cycle, and the bench relies on that ordering. Directed corner cases are followed by seeded random operations, and every result is compared with a reference table kept in the bench.

// File: rtl/slb_pkg.sv
// Shared constants and operation codes for the segment table.
// Assumes 64-bit tag and descriptor words with fixed field positions.
package slb_pkg;
    localparam int WORD_W    = 64;
    localparam int SLOT_W    = 12;  // slot number width in the address operand
    localparam int VALID_BIT = 27;  // valid flag inside the tag word
    localparam int SEG_S_LSB = 28;  // lowest tag bit of a 256 MB segment
    localparam int SEG_L_LSB = 40;  // lowest tag bit of a 1 TB segment
    localparam int SIZE_HI   = 63;  // size field in the descriptor word
    localparam int SIZE_LO   = 62;

    typedef enum logic [2:0] {
        OP_WRITE   = 3'd0,
        OP_RD_TAG  = 3'd1,
        OP_RD_DESC = 3'd2,
        OP_SEARCH  = 3'd3,
        OP_INV     = 3'd4,
        OP_INV_G   = 3'd5,
        OP_INV_ALL = 3'd6
    } slb_op_e;
endpackage

// File: rtl/slb_entry_match.sv
// Compares one stored slot against an address under that slot's own
// segment size. Assumes size code 00 = 256 MB and 01 = 1 TB.
module slb_entry_match
    import slb_pkg::*;
(
    input  logic [WORD_W-1:0] tag_word,
    input  logic [WORD_W-1:0] desc_word,
    input  logic [WORD_W-1:0] ea,
    output logic              hit
);
    logic [WORD_W-1:0] key_small;
    logic [WORD_W-1:0] key_large;

    // Build the two expected tag words and pick by the size field
    always_comb begin
        key_small = '0;
        key_large = '0;
        key_small[WORD_W-1:SEG_S_LSB] = ea[WORD_W-1:SEG_S_LSB];
        key_large[WORD_W-1:SEG_L_LSB] = ea[WORD_W-1:SEG_L_LSB];
        key_small[VALID_BIT] = 1'b1;
        key_large[VALID_BIT] = 1'b1;
        hit = ((tag_word == key_small) && (desc_word[SIZE_HI:SIZE_LO] == 2'b00))
           || ((tag_word == key_large) && (desc_word[SIZE_HI:SIZE_LO] == 2'b01));
    end
endmodule

// File: rtl/slb_first_hit.sv
// Reduces a raw match vector to the lowest-numbered match.
// Assumes N >= 2.
module slb_first_hit #(
    parameter int N     = 32,
    parameter int IDX_W = $clog2(N)
) (
    input  logic [N-1:0]     raw,
    output logic [N-1:0]     onehot,
    output logic [IDX_W-1:0] idx,
    output logic             any
);
    // Scan from the top so the lowest match is written last
    always_comb begin
        onehot = '0;
        idx    = '0;
        any    = 1'b0;
        for (int i = N - 1; i >= 0; i--) begin
            if (raw[i]) begin
                onehot    = '0;
                onehot[i] = 1'b1;
                idx       = IDX_W'(i);
                any       = 1'b1;
            end
        end
    end
endmodule

// File: rtl/slb_write_check.sv
// Flags an illegal slot write: slot range, reserved tag bits, size code
// and page-size code. Assumes the page-size code is {data[8], data[5:4]}.
module slb_write_check
    import slb_pkg::*;
#(
    parameter int            N         = 32,
    parameter bit            ONE_TB_EN = 1'b1,
    parameter int            NUM_PAGE  = 3,
    parameter logic [NUM_PAGE*3-1:0] PAGE_ENCS = 9'b100_101_000
) (
    input  logic [WORD_W-1:0] addr,
    input  logic [WORD_W-1:0] data,
    output logic              bad
);
    logic       page_ok;
    logic [2:0] page_code;

    assign page_code = {data[8], data[5:4]};

    // Look the page-size code up in the configured list
    always_comb begin
        page_ok = 1'b0;
        for (int p = 0; p < NUM_PAGE; p++) begin
            if (page_code == PAGE_ENCS[p*3 +: 3]) page_ok = 1'b1;
        end
    end

    // Combine all refusal reasons
    always_comb begin
        bad = (addr[SLOT_W-1:0] >= SLOT_W'(N))
           || (addr[VALID_BIT-1:SLOT_W] != '0)
           || data[SIZE_HI]
           || (data[SIZE_LO] && !ONE_TB_EN)
           || !page_ok;
    end
endmodule

// File: rtl/slb_array.sv
// Segment table: parallel lookup port plus one maintenance operation per
// cycle. Responses and lookup results are registered one cycle later.
// Assumes a synchronous active-low reset and NUM_ENTRIES <= 4096.
module slb_array
    import slb_pkg::*;
#(
    parameter int            NUM_ENTRIES = 32,
    parameter bit            ONE_TB_EN   = 1'b1,
    parameter int            NUM_PAGE    = 3,
    parameter logic [NUM_PAGE*3-1:0] PAGE_ENCS = 9'b100_101_000,
    localparam int           IDX_W       = $clog2(NUM_ENTRIES)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   mode64,
    input  logic                   op_valid,
    input  logic [2:0]             op_code,
    input  logic [63:0]            op_addr,
    input  logic [63:0]            op_data,
    output logic                   rsp_valid,
    output logic                   rsp_err,
    output logic [63:0]            rsp_data,
    output logic                   flush_local,
    output logic                   flush_global,
    input  logic                   lk_valid,
    input  logic [63:0]            lk_ea,
    output logic [NUM_ENTRIES-1:0] lk_hit_vec,
    output logic                   lk_rsp_valid,
    output logic                   lk_rsp_hit,
    output logic [IDX_W-1:0]       lk_rsp_idx,
    output logic [63:0]            lk_rsp_vsid
);
    logic [WORD_W-1:0]      tag_q  [NUM_ENTRIES];
    logic [WORD_W-1:0]      desc_q [NUM_ENTRIES];
    logic [NUM_ENTRIES-1:0] valid_vec;
    logic [NUM_ENTRIES-1:0] lk_raw, op_raw, op_onehot;
    logic [IDX_W-1:0]       lk_idx, op_idx, slot_idx;
    logic                   lk_any, op_any, wr_bad, slot_ok;
    slb_op_e                op_e;

    assign op_e     = slb_op_e'(op_code);
    assign slot_idx = op_addr[IDX_W-1:0];
    assign slot_ok  = op_addr[SLOT_W-1:0] < SLOT_W'(NUM_ENTRIES);

    // One matcher per slot for each of the two address sources
    for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_slot
        assign valid_vec[g] = tag_q[g][VALID_BIT];
        slb_entry_match u_lk_m (.tag_word(tag_q[g]), .desc_word(desc_q[g]),
                                .ea(lk_ea), .hit(lk_raw[g]));
        slb_entry_match u_op_m (.tag_word(tag_q[g]), .desc_word(desc_q[g]),
                                .ea(op_addr), .hit(op_raw[g]));
    end

    slb_first_hit #(.N(NUM_ENTRIES), .IDX_W(IDX_W)) u_lk_pick (
        .raw(lk_raw), .onehot(lk_hit_vec), .idx(lk_idx), .any(lk_any));
    slb_first_hit #(.N(NUM_ENTRIES), .IDX_W(IDX_W)) u_op_pick (
        .raw(op_raw), .onehot(op_onehot), .idx(op_idx), .any(op_any));

    slb_write_check #(.N(NUM_ENTRIES), .ONE_TB_EN(ONE_TB_EN),
                      .NUM_PAGE(NUM_PAGE), .PAGE_ENCS(PAGE_ENCS)) u_wchk (
        .addr(op_addr), .data(op_data), .bad(wr_bad));

    // Maintenance operations: table update and registered response
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_ENTRIES; i++) begin
                tag_q[i]  <= '0;
                desc_q[i] <= '0;
            end
            rsp_valid    <= 1'b0;
            rsp_err      <= 1'b0;
            rsp_data     <= '0;
            flush_local  <= 1'b0;
            flush_global <= 1'b0;
        end else begin
            rsp_valid    <= op_valid;
            rsp_err      <= 1'b0;
            rsp_data     <= '0;
            flush_local  <= 1'b0;
            flush_global <= 1'b0;
            if (op_valid) begin
                case (op_e)
                    OP_WRITE: begin
                        if (wr_bad) rsp_err <= 1'b1;
                        else begin
                            tag_q[slot_idx]  <= {op_addr[WORD_W-1:SLOT_W], {SLOT_W{1'b0}}};
                            desc_q[slot_idx] <= op_data;
                        end
                    end
                    OP_RD_TAG: begin
                        if (!slot_ok) rsp_err <= 1'b1;
                        else rsp_data <= tag_q[slot_idx];
                    end
                    OP_RD_DESC: begin
                        if (!slot_ok) rsp_err <= 1'b1;
                        else rsp_data <= desc_q[slot_idx];
                    end
                    OP_SEARCH: begin
                        if (!mode64) rsp_err <= 1'b1;
                        else rsp_data <= op_any ? desc_q[op_idx] : '1;
                    end
                    OP_INV, OP_INV_G: begin
                        if (op_any) begin
                            tag_q[op_idx][VALID_BIT] <= 1'b0;
                            flush_local  <= (op_e == OP_INV);
                            flush_global <= (op_e == OP_INV_G);
                        end
                    end
                    OP_INV_ALL: begin
                        for (int i = 1; i < NUM_ENTRIES; i++) tag_q[i][VALID_BIT] <= 1'b0;
                        flush_local <= |valid_vec[NUM_ENTRIES-1:1];
                    end
                    default: ;
                endcase
            end
        end
    end

    // Lookup port: register the winner and its descriptor
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lk_rsp_valid <= 1'b0;
            lk_rsp_hit   <= 1'b0;
            lk_rsp_idx   <= '0;
            lk_rsp_vsid  <= '0;
        end else begin
            lk_rsp_valid <= lk_valid;
            lk_rsp_hit   <= lk_valid && lk_any;
            lk_rsp_idx   <= lk_idx;
            lk_rsp_vsid  <= (lk_valid && lk_any) ? desc_q[lk_idx] : '0;
        end
    end

    // R4
    lk_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(lk_hit_vec) && $onehot0(op_onehot));

    // R12
    lk_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && lk_any) |=> (lk_rsp_valid && lk_rsp_hit && lk_rsp_idx == $past(lk_idx)));

    // R6
    bad_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_e == OP_WRITE && wr_bad) |=> (rsp_err && valid_vec == $past(valid_vec)));

    // R9
    search_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_e == OP_SEARCH && mode64 && !op_any) |=> (rsp_data == '1 && !rsp_err));

    // R10
    flush_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(flush_local && flush_global));

    // R11
    slot0_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_e == OP_INV_ALL) |=> (tag_q[0] == $past(tag_q[0])));
endmodule

// File: tb/sim_slb_array.sv
// Bench for slb_array: directed corner cases, then seeded random operations,
// all compared against a reference table held in the bench.
module sim_slb_array;
    localparam int N     = 32;
    localparam int IDX_W = $clog2(N);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic mode64 = 1'b1;
    logic op_valid = 1'b0;
    logic [2:0] op_code = '0;
    logic [63:0] op_addr = '0, op_data = '0;
    logic lk_valid = 1'b0;
    logic [63:0] lk_ea = '0;
    logic rsp_valid, rsp_err, flush_local, flush_global;
    logic [63:0] rsp_data;
    logic [N-1:0] lk_hit_vec;
    logic lk_rsp_valid, lk_rsp_hit;
    logic [IDX_W-1:0] lk_rsp_idx;
    logic [63:0] lk_rsp_vsid;
    // second instance with 1 TB segments disabled
    logic b_rsp_valid, b_rsp_err, b_fl, b_fg, b_lv, b_lh;
    logic [63:0] b_rsp_data, b_lvs;
    logic [N-1:0] b_hv;
    logic [IDX_W-1:0] b_li;

    int checks = 0;
    int errors = 0;
    logic [63:0] tag_m [N];
    logic [63:0] desc_m [N];

    always #2 clk = ~clk;

    slb_array #(.NUM_ENTRIES(N)) u0 (
        .clk, .rst_n, .mode64, .op_valid, .op_code, .op_addr, .op_data,
        .rsp_valid, .rsp_err, .rsp_data, .flush_local, .flush_global,
        .lk_valid, .lk_ea, .lk_hit_vec, .lk_rsp_valid, .lk_rsp_hit,
        .lk_rsp_idx, .lk_rsp_vsid);

    slb_array #(.NUM_ENTRIES(N), .ONE_TB_EN(1'b0)) u1 (
        .clk, .rst_n, .mode64, .op_valid, .op_code, .op_addr, .op_data,
        .rsp_valid(b_rsp_valid), .rsp_err(b_rsp_err), .rsp_data(b_rsp_data),
        .flush_local(b_fl), .flush_global(b_fg), .lk_valid, .lk_ea,
        .lk_hit_vec(b_hv), .lk_rsp_valid(b_lv), .lk_rsp_hit(b_lh),
        .lk_rsp_idx(b_li), .lk_rsp_vsid(b_lvs));

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // winning slot for an address under the R2/R3 rules, -1 on a miss
    function automatic int model_find(input logic [63:0] ea);
        logic [63:0] ks, kl;
        ks = {ea[63:28], 1'b1, 27'b0};
        kl = {ea[63:40], 12'b0, 1'b1, 27'b0};
        for (int i = 0; i < N; i++)
            if ((tag_m[i] == ks && desc_m[i][63:62] == 2'b00) ||
                (tag_m[i] == kl && desc_m[i][63:62] == 2'b01)) return i;
        return -1;
    endfunction

    // R6/R7 refusal rules
    function automatic bit model_bad(input logic [63:0] a, input logic [63:0] d, input bit tb_en);
        logic [2:0] pc;
        pc = {d[8], d[5:4]};
        return (a[11:0] >= 12'(N)) || (a[26:12] != 0) || d[63] || (d[62] && !tb_en)
            || !(pc == 3'b000 || pc == 3'b101 || pc == 3'b100);
    endfunction

    function automatic logic [63:0] mk_desc(input logic [1:0] sz, input logic [2:0] pc, input logic [63:0] r);
        logic [63:0] d;
        d = r;
        d[63:62] = sz;
        d[8] = pc[2];
        d[5:4] = pc[1:0];
        return d;
    endfunction

    task automatic do_op(input logic [2:0] code, input logic [63:0] a, input logic [63:0] d);
        bit e_err, e_fl, e_fg, any_v;
        logic [63:0] e_data;
        int k;
        e_err = 0; e_fl = 0; e_fg = 0; e_data = '0;
        k = model_find(a);
        case (code)
            3'd0: begin
                e_err = model_bad(a, d, 1'b1);
                if (!e_err) begin tag_m[a[4:0]] = {a[63:12], 12'b0}; desc_m[a[4:0]] = d; end
            end
            3'd1, 3'd2: begin
                e_err = (a[11:0] >= 12'(N));
                if (!e_err) e_data = (code == 3'd1) ? tag_m[a[4:0]] : desc_m[a[4:0]];
            end
            3'd3: begin
                e_err = !mode64;
                if (!e_err) e_data = (k >= 0) ? desc_m[k] : '1;
            end
            3'd4, 3'd5: if (k >= 0) begin
                tag_m[k][27] = 1'b0;
                e_fl = (code == 3'd4); e_fg = (code == 3'd5);
            end
            3'd6: begin
                any_v = 0;
                for (int i = 1; i < N; i++) begin any_v |= tag_m[i][27]; tag_m[i][27] = 1'b0; end
                e_fl = any_v;
            end
            default: ;
        endcase
        @(negedge clk);
        op_valid = 1'b1; op_code = code; op_addr = a; op_data = d;
        @(posedge clk); #1;
        op_valid = 1'b0;
        chk(rsp_valid == 1'b1, "R5 rsp_valid", 64'(rsp_valid), 64'd1);
        chk(rsp_err == e_err, (code == 3'd0) ? "R6/R7 write error" :
            (code == 3'd3) ? "R9 search error" : "R8 read error", 64'(rsp_err), 64'(e_err));
        chk(rsp_data == e_data, (code == 3'd3) ? "R9 search data" : "R5 read data", rsp_data, e_data);
        chk(flush_local == e_fl, (code == 3'd6) ? "R11 local flush" : "R10 local flush",
            64'(flush_local), 64'(e_fl));
        chk(flush_global == e_fg, "R10 global flush", 64'(flush_global), 64'(e_fg));
    endtask

    task automatic do_lk(input logic [63:0] ea);
        int k;
        logic [N-1:0] e_vec;
        k = model_find(ea);
        e_vec = '0;
        if (k >= 0) e_vec[k] = 1'b1;
        @(negedge clk);
        lk_valid = 1'b1; lk_ea = ea;
        #1;
        chk(lk_hit_vec == e_vec, "R2/R3/R4 hit vector", 64'(lk_hit_vec), 64'(e_vec));
        @(posedge clk); #1;
        lk_valid = 1'b0;
        chk(lk_rsp_valid && lk_rsp_hit == (k >= 0), "R12 registered hit", 64'(lk_rsp_hit), 64'(k >= 0));
        if (k >= 0) chk(lk_rsp_idx == IDX_W'(k), "R12 registered index", 64'(lk_rsp_idx), 64'(k));
        chk(lk_rsp_vsid == ((k >= 0) ? desc_m[k] : 64'd0), "R12 registered word",
            lk_rsp_vsid, (k >= 0) ? desc_m[k] : 64'd0);
    endtask

    function automatic logic [63:0] wa(input logic [63:0] tag_hi, input int slot);
        logic [63:0] a;
        a = tag_hi;
        a[27] = 1'b1;
        a[26:0] = '0;
        a[11:0] = 12'(slot);
        return a;
    endfunction

    initial begin
        #(4 * 200000);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [63:0] a, d, t;
        void'($urandom(32'd4242));
        for (int i = 0; i < N; i++) begin tag_m[i] = '0; desc_m[i] = '0; end
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R1 reset state
        do_lk(64'h0);
        do_op(3'd1, 64'd0, 0);
        do_op(3'd2, 64'd31, 0);
        // R2 256 MB slot, R5 write/read back
        do_op(3'd0, wa(64'h1234_5678_9000_0000, 3), mk_desc(2'b00, 3'b000, 64'hABC));
        do_op(3'd1, 64'd3, 0);
        do_lk(64'h1234_5678_9ABC_DEF0);
        do_lk(64'h1234_5678_A000_0000);
        // R3 1 TB slot
        do_op(3'd0, wa(64'h00AB_CD00_0000_0000, 5), mk_desc(2'b01, 3'b101, 64'h55));
        do_lk(64'h00AB_CDFF_FFFF_FFFF);
        do_lk(64'h00AB_CE00_0000_0000);
        // R4 duplicate tag: lowest slot wins
        do_op(3'd0, wa(64'h7000_0000_1000_0000, 9), mk_desc(2'b00, 3'b100, 64'h9));
        do_op(3'd0, wa(64'h7000_0000_1000_0000, 2), mk_desc(2'b00, 3'b000, 64'h2));
        do_lk(64'h7000_0000_1234_5678);
        // R6/R7 refused writes, table unchanged
        do_op(3'd0, wa(64'h4000_0000_0000_0000, 40), mk_desc(2'b00, 3'b000, 0));
        a = wa(64'h4000_0000_0000_0000, 7); a[15] = 1'b1;
        do_op(3'd0, a, mk_desc(2'b00, 3'b000, 0));
        do_op(3'd0, wa(64'h4000_0000_0000_0000, 7), mk_desc(2'b10, 3'b000, 0));
        do_op(3'd0, wa(64'h4000_0000_0000_0000, 7), mk_desc(2'b00, 3'b011, 0));
        do_op(3'd2, 64'd7, 0);
        do_lk(64'h4000_0000_0000_0000);
        // R6 1 TB refused when disabled (second instance)
        @(negedge clk);
        op_valid = 1'b1; op_code = 3'd0; op_addr = wa(64'h0100_0000_0000_0000, 12);
        op_data = mk_desc(2'b01, 3'b000, 0);
        @(posedge clk); #1;
        op_valid = 1'b0;
        chk(b_rsp_err == 1'b1, "R6 1 TB disabled", 64'(b_rsp_err), 64'd1);
        chk(rsp_err == 1'b0, "R6 1 TB enabled", 64'(rsp_err), 64'd0);
        tag_m[12] = {op_addr[63:12], 12'b0}; desc_m[12] = op_data;
        // R8 out of range reads
        do_op(3'd1, 64'd32, 0);
        do_op(3'd2, 64'd4095, 0);
        // R9 search
        do_op(3'd3, 64'h1234_5678_9000_0000, 0);
        do_op(3'd3, 64'h6666_0000_0000_0000, 0);
        mode64 = 1'b0;
        do_op(3'd3, 64'h1234_5678_9000_0000, 0);
        mode64 = 1'b1;
        // R10 invalidate by address
        do_op(3'd4, 64'h7000_0000_1000_0000, 0);
        do_lk(64'h7000_0000_1000_0000);
        do_op(3'd5, 64'h7000_0000_1000_0000, 0);
        do_op(3'd4, 64'h7000_0000_1000_0000, 0);
        // R11 invalidate-all spares slot 0
        do_op(3'd0, wa(64'h0F00_0000_0000_0000, 0), mk_desc(2'b00, 3'b000, 64'h1));
        do_op(3'd6, 0, 0);
        do_lk(64'h0F00_0000_0000_0000);
        do_op(3'd1, 64'd0, 0);
        do_op(3'd1, 64'd3, 0);
        do_op(3'd6, 0, 0);
        // random phase
        for (int it = 0; it < 400; it++) begin
            int sel, k;
            sel = $urandom % 10;
            k = $urandom % N;
            t = 64'({$urandom, $urandom});
            if (sel < 3) begin
                logic [1:0] sz;
                logic [2:0] pc;
                sz = ($urandom % 16 == 0) ? 2'b10 : 2'($urandom % 2);
                pc = ($urandom % 10 == 0) ? 3'b011 : (($urandom % 3 == 0) ? 3'b101 :
                     (($urandom % 2 == 0) ? 3'b100 : 3'b000));
                a = '0;
                a[63:40] = 24'($urandom % 4);
                if (sz != 2'b01) a[39:28] = 12'($urandom % 4);
                a[27] = ($urandom % 8 != 0);
                if ($urandom % 20 == 0) a[20] = 1'b1;
                a[11:0] = 12'($urandom % (N + 4));
                do_op(3'd0, a, mk_desc(sz, pc, t));
            end else if (sel < 6) begin
                a = t;
                if ($urandom % 4 != 0) begin
                    if (desc_m[k][62]) a[63:40] = tag_m[k][63:40];
                    else a[63:28] = tag_m[k][63:28];
                end
                do_lk(a);
            end else if (sel == 6) begin
                do_op(3'(1 + $urandom % 2), 64'($urandom % (N + 4)), 0);
            end else if (sel == 7) begin
                a = t; a[63:28] = tag_m[k][63:28];
                if (desc_m[k][62]) a[39:28] = t[39:28];
                do_op(3'd3, a, 0);
            end else if (sel == 8) begin
                a = t; a[63:28] = tag_m[k][63:28];
                do_op(3'(4 + $urandom % 2), a, 0);
            end else if ($urandom % 4 == 0) begin
                do_op(3'd6, 0, 0);
            end
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule